// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and date in packed BCD from a 32.768 kHz oscillator. A prescaler turns the oscillator clock into a once-per-second count enable. A cascade of BCD counters then advances seconds, minutes, hours, day of month, month and a two-digit year, with a separate weekday counter. Hours count either 00 to 23 or 12-hour style with a PM flag. The year 00 to 99 stands for 2000 to 2099, so every year divisible by four is a leap year.

Software reaches the block through a byte-wide register port. Counter registers take writes only while counting is stopped. A control register holds the run bit, a self-clearing soft-reset bit and the hour-format select. A status register holds a carry flag, which is set each time the seconds advance. With it, software can detect a rollover that lands in the middle of a multi-byte read and read again. The soft reset stays busy for a set number of oscillator cycles before it clears itself.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After hardware reset the time reads 00:00:00, weekday 0, day 01, month 01, year 00. The control register reads 0x40 (stopped, 24-hour format) and the status register reads 0x00.
- R2: While the run bit (control bit 0) is set, the seconds advance once every PRESCALE_DIV clock cycles. The first advance happens PRESCALE_DIV cycles after the run bit is written. Stopping the count restarts the prescaler from zero.
- R3: Seconds and minutes wrap 59 to 00, each wrap carrying into the next field. In 24-hour format the hour wraps 23 to 00 and carries into the day.
- R4: In 12-hour format (control bit 6 clear) the hour register holds BCD 01..12 in bits 5:0 and a PM flag in bit 6. Hour 11 goes to 12 and toggles PM, and 12 goes to 01. The day advances only on the step from 11 PM to 12 AM.
- R5: The day of month wraps to 01 after the last day of its month: 30 for months 04, 06, 09 and 11, 31 for the other months, and 28 or 29 for month 02. Each day step advances the weekday, which wraps 6 to 0.
- R6: February has 29 days when the BCD year is divisible by four, 00 included. Month 12 wraps to 01 and carries into the year, and the year wraps 99 to 00.
- R7: The counter registers sit at addresses 0 (seconds), 1 (minutes), 2 (hours), 3 (weekday), 4 (day), 5 (month) and 6 (year). Each keeps only its own field bits (7, 7, 7, 3, 6, 5 and 8 bits) and reads the unused bits as zero. A write to a counter register takes effect only while the run bit is clear and no soft reset is busy.
- R8: The control register is at address 9. A write to it loads bit 6 (hour format) only if counting was already stopped before that write, so a write that stops the count leaves the format unchanged.
- R9: Status bit 1 (address 8) is set on every seconds advance. Writing 0 to that bit clears it and writing 1 leaves it unchanged. When a clear and an advance fall in the same cycle, the flag stays set.
- R10: Writing 1 to control bit 1 loads the counters with their reset values and clears the run bit. The hour reset value is 00 in 24-hour format and 0x12 in 12-hour format. Bit 1 then reads 1 for RST_CYCLES cycles and clears itself. While it is set, writes to the counter and control registers are ignored, and the hour format is kept.
- R11: Control bit 7 (count mode) always reads 0, because the block counts only in calendar mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz oscillator clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe, sampled at the rising clock edge |
| addr | input | 4 | Register address for reads and writes |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Combinational read data for the register at addr |

## Verification
Two events can fall in the same cycle. A status write that clears the carry flag can land on the cycle in which the prescaler fires a seconds advance. The bench counts clock edges from the run-bit write and places the clear write exactly on the PRESCALE_DIV-th edge. It then checks that the seconds moved and that the flag still reads set, and a second clear one cycle later must take effect. A counter write that arrives while the clock is running is handled the same way: it is placed between advances, and the bench confirms afterwards that the seconds hold the counted value and not the written one.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hour;
        logic [2:0] wday;
        logic [5:0] mday;
        logic [4:0] mon;
        logic [7:0] year;
    } cal_time_t;

    localparam logic [3:0] A_SEC  = 4'd0;
    localparam logic [3:0] A_MIN  = 4'd1;
    localparam logic [3:0] A_HOUR = 4'd2;
    localparam logic [3:0] A_WDAY = 4'd3;
    localparam logic [3:0] A_MDAY = 4'd4;
    localparam logic [3:0] A_MON  = 4'd5;
    localparam logic [3:0] A_YEAR = 4'd6;
    localparam logic [3:0] A_STAT = 4'd8;
    localparam logic [3:0] A_CTRL = 4'd9;

    localparam cal_time_t CAL_RESET = '{sec: 7'h00, min: 7'h00, hour: 7'h00,
                                        wday: 3'd0, mday: 6'h01, mon: 5'h01,
                                        year: 8'h00};

    // Next BCD value of a two-digit number (no wrap handling).
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Year in BCD is divisible by four.
    function automatic logic leap_year(input logic [7:0] y);
        if (y[4])
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else
            return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    // Last day of a month, as BCD.
    function automatic logic [7:0] month_len(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (cnt_q == LAST)
            cnt_d = '0;
        else
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // A nonzero count exists only if the block was running one cycle ago.
    assert_cnt_only_when_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> $past(run));

    // The count steps by one while running below its limit.
    assert_cnt_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/cal_rollover.sv
module cal_rollover
    import cal_pkg::*;
(
    input  cal_time_t cur,
    input  logic      hr24,
    output cal_time_t nxt
);
    logic c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        nxt   = cur;
        c_min = (cur.sec == 7'h59);
        c_hr  = c_min && (cur.min == 7'h59);
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;

        nxt.sec = c_min ? 7'h00 : 7'(bcd_step({1'b0, cur.sec}));

        if (c_min)
            nxt.min = c_hr ? 7'h00 : 7'(bcd_step({1'b0, cur.min}));

        if (c_hr) begin
            if (hr24) begin
                if (cur.hour[5:0] == 6'h23) begin
                    nxt.hour = 7'h00;
                    c_day    = 1'b1;
                end else begin
                    nxt.hour = {1'b0, 6'(bcd_step({2'b00, cur.hour[5:0]}))};
                end
            end else begin
                if (cur.hour[5:0] == 6'h11) begin
                    nxt.hour = {~cur.hour[6], 6'h12};
                    c_day    = cur.hour[6];
                end else if (cur.hour[5:0] == 6'h12) begin
                    nxt.hour = {cur.hour[6], 6'h01};
                end else begin
                    nxt.hour = {cur.hour[6], 6'(bcd_step({2'b00, cur.hour[5:0]}))};
                end
            end
        end

        if (c_day) begin
            nxt.wday = (cur.wday == 3'd6) ? 3'd0 : cur.wday + 3'd1;
            if ({2'b00, cur.mday} == month_len(cur.mon, cur.year)) begin
                nxt.mday = 6'h01;
                c_mon    = 1'b1;
            end else begin
                nxt.mday = 6'(bcd_step({2'b00, cur.mday}));
            end
        end

        if (c_mon) begin
            if (cur.mon == 5'h12) begin
                nxt.mon = 5'h01;
                c_yr    = 1'b1;
            end else begin
                nxt.mon = 5'(bcd_step({3'b000, cur.mon}));
            end
        end

        if (c_yr)
            nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_step(cur.year);
    end

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import cal_pkg::*;
#(
    parameter int PRESCALE_DIV = 32768,
    parameter int RST_CYCLES   = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data
);
    localparam int RCW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [RCW-1:0] RST_LOAD = RCW'(RST_CYCLES - 1);

    typedef struct packed {
        cal_time_t      t;
        logic           run;
        logic           hr24;
        logic           carry;
        logic           busy;
        logic [RCW-1:0] rst_cnt;
    } state_t;

    state_t    st_d, st_q;
    logic      tick;
    logic      rst_req;
    logic      cnt_wr_ok;
    cal_time_t rolled;

    cal_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st_q.run),
        .tick (tick)
    );

    cal_rollover u_roll (
        .cur (st_q.t),
        .hr24(st_q.hr24),
        .nxt (rolled)
    );

    always_comb begin
        st_d      = st_q;
        rst_req   = 1'b0;
        cnt_wr_ok = wr_en && !st_q.run && !st_q.busy;

        if (st_q.busy) begin
            if (st_q.rst_cnt == '0) st_d.busy = 1'b0;
            else                    st_d.rst_cnt = st_q.rst_cnt - RCW'(1);
        end

        if (cnt_wr_ok) begin
            case (addr)
                A_SEC:   st_d.t.sec  = wr_data[6:0];
                A_MIN:   st_d.t.min  = wr_data[6:0];
                A_HOUR:  st_d.t.hour = wr_data[6:0];
                A_WDAY:  st_d.t.wday = wr_data[2:0];
                A_MDAY:  st_d.t.mday = wr_data[5:0];
                A_MON:   st_d.t.mon  = wr_data[4:0];
                A_YEAR:  st_d.t.year = wr_data;
                default: ;
            endcase
        end

        if (wr_en && addr == A_STAT && !wr_data[1])
            st_d.carry = 1'b0;

        if (wr_en && addr == A_CTRL && !st_q.busy) begin
            if (!st_q.run)
                st_d.hr24 = wr_data[6];
            if (wr_data[1]) begin
                rst_req        = 1'b1;
                st_d.run       = 1'b0;
                st_d.busy      = 1'b1;
                st_d.rst_cnt   = RST_LOAD;
                st_d.t         = CAL_RESET;
                st_d.t.hour    = st_d.hr24 ? 7'h00 : 7'h12;
            end else begin
                st_d.run = wr_data[0];
            end
        end

        // An advance overrides a simultaneous carry clear.
        if (tick) begin
            st_d.carry = 1'b1;
            if (!rst_req)
                st_d.t = rolled;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.t       <= CAL_RESET;
            st_q.run     <= 1'b0;
            st_q.hr24    <= 1'b1;
            st_q.carry   <= 1'b0;
            st_q.busy    <= 1'b0;
            st_q.rst_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (addr)
            A_SEC:   rd_data = {1'b0, st_q.t.sec};
            A_MIN:   rd_data = {1'b0, st_q.t.min};
            A_HOUR:  rd_data = {1'b0, st_q.t.hour};
            A_WDAY:  rd_data = {5'b0, st_q.t.wday};
            A_MDAY:  rd_data = {2'b0, st_q.t.mday};
            A_MON:   rd_data = {3'b0, st_q.t.mon};
            A_YEAR:  rd_data = st_q.t.year;
            A_STAT:  rd_data = {6'b0, st_q.carry, 1'b0};
            A_CTRL:  rd_data = {1'b0, st_q.hr24, 4'b0, st_q.busy, st_q.run};
            default: rd_data = 8'h00;
        endcase
    end

    // Stopped with no write: the time does not move.
    assert_stopped_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !wr_en) |=> $stable(st_q.t));

    // Counter writes while running are dropped.
    assert_running_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && wr_en && addr <= A_YEAR && !tick) |=> $stable(st_q.t));

    // Every prescaler tick leaves the carry flag set.
    assert_carry_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> st_q.carry);

    // A busy soft reset never coexists with counting.
    assert_busy_not_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> !st_q.run);

    // Seconds wrap from 59 to 00 on a tick.
    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.t.sec == 7'h59) |=> (st_q.t.sec == 7'h00));

endmodule

// File: tb/sim_bcd_calendar_clock.sv
module sim_bcd_calendar_clock;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;
    localparam int RSTC       = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int n_vec = 0;
    int n_bad = 0;
    bit hr24_m = 1'b1;
    int ms, mm, mh, mwd, md, mmo, my;

    bcd_calendar_clock #(.PRESCALE_DIV(DIV), .RST_CYCLES(RSTC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        addr = a;
        #1;
        v = int'(rd_data);
    endtask

    function automatic int bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int dim(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int enc_hour(input int h, input bit f24);
        int h12;
        if (f24) return bcd(h);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return ((h >= 12) ? 8'h40 : 8'h00) | bcd(h12);
    endfunction

    task automatic adv1();
        ms++;
        if (ms == 60) begin ms = 0; mm++; end
        if (mm == 60) begin mm = 0; mh++; end
        if (mh == 24) begin
            mh = 0; md++; mwd = (mwd + 1) % 7;
            if (md > dim(mmo, my)) begin md = 1; mmo++; end
            if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
        end
    endtask

    task automatic load_time();
        wr(4'd0, 8'(bcd(ms)));
        wr(4'd1, 8'(bcd(mm)));
        wr(4'd2, 8'(enc_hour(mh, hr24_m)));
        wr(4'd3, 8'(mwd));
        wr(4'd4, 8'(bcd(md)));
        wr(4'd5, 8'(bcd(mmo)));
        wr(4'd6, 8'(bcd(my)));
    endtask

    task automatic check_time();
        int v;
        rd(4'd0, v); check("R3", "seconds", v, bcd(ms));
        rd(4'd1, v); check("R3", "minutes", v, bcd(mm));
        rd(4'd2, v);
        if (hr24_m) check("R3", "hour 24h", v, enc_hour(mh, 1'b1));
        else        check("R4", "hour 12h", v, enc_hour(mh, 1'b0));
        rd(4'd3, v); check("R5", "weekday", v, mwd);
        rd(4'd4, v); check("R5", "day", v, bcd(md));
        rd(4'd5, v); check("R6", "month", v, bcd(mmo));
        rd(4'd6, v); check("R6", "year", v, bcd(my));
    endtask

    task automatic set_mode(input bit f24);
        hr24_m = f24;
        wr(4'd9, {1'b0, f24, 6'b0});
    endtask

    // Run for k seconds, stop mid-way through the next second, then compare.
    task automatic run_secs(input int k);
        int v;
        wr(4'd9, {1'b0, hr24_m, 6'b000001});
        repeat (k * DIV + DIV / 2 - 1) @(negedge clk);
        wr(4'd9, {1'b0, hr24_m, 6'b000000});
        for (int i = 0; i < k; i++) adv1();
        rd(4'd8, v); check("R9", "carry after run", v, (k > 0) ? 2 : 0);
        wr(4'd8, 8'h00);
        check_time();
    endtask

    task automatic scenario(input int s, input int m, input int h, input int wd,
                            input int d, input int mo, input int y, input int k);
        ms = s; mm = m; mh = h; mwd = wd; md = d; mmo = mo; my = y;
        load_time();
        run_secs(k);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        ms = 0; mm = 0; mh = 0; mwd = 0; md = 1; mmo = 1; my = 0;
        rd(4'd9, v); check("R1", "control", v, 8'h40);
        rd(4'd8, v); check("R1", "status", v, 8'h00);
        check_time();

        // R2 timing, R9 clear versus advance, R7 write while running
        wr(4'd9, 8'h41);
        repeat (DIV - 1) @(negedge clk);
        rd(4'd0, v); check("R2", "sec before first tick", v, 8'h00);
        wr(4'd8, 8'h00);
        rd(4'd0, v); check("R2", "sec after first tick", v, 8'h01);
        rd(4'd8, v); check("R9", "advance wins over clear", v, 8'h02);
        wr(4'd8, 8'h02);
        rd(4'd8, v); check("R9", "writing one keeps flag", v, 8'h02);
        wr(4'd8, 8'h00);
        rd(4'd8, v); check("R9", "clear", v, 8'h00);
        wr(4'd0, 8'h30);
        rd(4'd0, v); check("R7", "write while running ignored", v, 8'h01);
        wr(4'd9, 8'h40);
        rd(4'd9, v); check("R2", "stopped control", v, 8'h40);
        wr(4'd9, 8'h41);
        repeat (DIV - 1) @(negedge clk);
        rd(4'd0, v); check("R2", "prescaler restarted", v, 8'h01);
        @(negedge clk);
        rd(4'd0, v); check("R2", "second tick after restart", v, 8'h02);
        wr(4'd9, 8'h40);
        wr(4'd8, 8'h00);
        wr(4'd0, 8'hD5);
        rd(4'd0, v); check("R7", "field masking", v, 8'h55);
        wr(4'd3, 8'hFF);
        rd(4'd3, v); check("R7", "weekday mask", v, 8'h07);

        // R8 format bit only from a write made while stopped; R11
        wr(4'd9, 8'h41);
        wr(4'd9, 8'h00);
        rd(4'd9, v); check("R8", "format kept by stop write", v, 8'h40);
        wr(4'd9, 8'h00);
        rd(4'd9, v); check("R8", "format taken when stopped", v, 8'h00);
        wr(4'd9, 8'hC0);
        rd(4'd9, v); check("R11", "count mode reads zero", v, 8'h40);
        hr24_m = 1'b1;
        wr(4'd8, 8'h00);

        // R5 R6 calendar corners in 24-hour format
        scenario(59, 59, 23, 3, 28, 2, 24, 1);
        scenario(59, 59, 23, 4, 28, 2, 23, 1);
        scenario(59, 59, 23, 5, 29, 2, 24, 1);
        scenario(59, 59, 23, 6, 31, 12, 99, 1);
        scenario(59, 59, 23, 1, 30, 4, 10, 1);
        scenario(59, 59, 23, 2, 31, 1, 50, 1);
        scenario(59, 59, 23, 0, 28, 2, 0, 1);
        scenario(58, 59, 22, 2, 30, 11, 7, 3);

        // R4 12-hour format
        set_mode(1'b0);
        scenario(59, 59, 23, 6, 15, 6, 31, 1);
        scenario(59, 59, 11, 2, 15, 6, 31, 1);
        scenario(59, 59, 12, 2, 15, 6, 31, 1);
        scenario(59, 59, 0, 2, 15, 6, 31, 1);

        // R10 soft reset
        set_mode(1'b1);
        ms = 12; mm = 34; mh = 5; mwd = 3; md = 9; mmo = 9; my = 44;
        load_time();
        wr(4'd9, 8'h43);
        rd(4'd9, v); check("R10", "busy and stopped", v, 8'h42);
        rd(4'd0, v); check("R10", "seconds cleared", v, 8'h00);
        rd(4'd2, v); check("R10", "hour cleared", v, 8'h00);
        rd(4'd4, v); check("R10", "day reset", v, 8'h01);
        wr(4'd0, 8'h15);
        wr(4'd9, 8'h41);
        repeat (RSTC - 3) @(negedge clk);
        rd(4'd9, v); check("R10", "busy last cycle", v, 8'h42);
        @(negedge clk);
        rd(4'd9, v); check("R10", "self clear", v, 8'h40);
        rd(4'd0, v); check("R10", "write during busy ignored", v, 8'h00);
        wr(4'd9, 8'h02);
        rd(4'd2, v); check("R10", "12h reset hour", v, 8'h12);
        repeat (RSTC) @(negedge clk);
        rd(4'd9, v); check("R10", "12h format kept", v, 8'h00);
        wr(4'd8, 8'h00);

        // Random times, mixed formats and run lengths
        for (int it = 0; it < 60; it++) begin
            int y, mo, d, h, m, s, wd, k;
            set_mode(1'(($urandom % 2)));
            y  = int'($urandom % 100);
            mo = 1 + int'($urandom % 12);
            d  = ($urandom % 2) ? dim(mo, y) : 1 + int'($urandom % dim(mo, y));
            h  = ($urandom % 2) ? 23 : int'($urandom % 24);
            m  = ($urandom % 2) ? 59 : int'($urandom % 60);
            s  = 50 + int'($urandom % 10);
            wd = int'($urandom % 7);
            k  = 1 + int'($urandom % 12);
            scenario(s, m, h, wd, d, mo, y, k);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule